// File: doc/BRIEF.md
# Nibble-to-Code-Group Transmit Encoder

This block sits in a 100 Mb/s twisted-pair transmit path. On every symbol clock it takes one 4-bit nibble from the MAC-side transmit interface, together with a transmit-enable strobe and a transmit-error flag. It returns one registered 5-bit code group. Between frames it emits the idle group. When a frame begins, the first two nibbles it receives are preamble. The block drops them and sends the two-group start delimiter in their place. When transmit-enable falls, it sends the two-group end delimiter and then goes back to idle.

Data nibbles map through the fixed 16-entry 4-to-5 table, which holds only legal data groups. While the error flag is raised during the data phase, the halt group replaces the data group. A thin top joins a control state machine to a registered output datapath. They share a small struct of select strobes. Every output group appears one clock after the inputs that caused it are sampled.

Top module: `nibble_group_encoder`

## Requirements
- R1: During reset, and on every clock while no frame is in progress and txEn is low, codeOut is the idle group 5'b11111.
- R2: When txEn is sampled high with no frame in progress (after idle or after the second end group), codeOut becomes 5'b11000 on that clock edge. The nibble is discarded.
- R3: The clock after 5'b11000 always gives 5'b10001, whatever txEn, txErr or the nibble are. That nibble is also discarded.
- R4: After the start pair, each clock on which txEn is sampled high gives the encoded nibble one clock later. The table is 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R5: In the data phase, a clock with txEn and txErr both high gives the halt group 5'b00100 in place of the data group.
- R6: The first clock with txEn sampled low after the start pair gives 5'b01101. The next clock gives 5'b00111, whatever the inputs are.
- R7: After 5'b00111, the block returns to idle if txEn is low. If txEn is high, it goes straight to 5'b11000, so back-to-back frames are possible.
- R8: txErr has no effect outside the data phase: it does nothing in idle, the start pair or the end pair.
- R9: codeOut is never 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 11001, 10000, or any other group that lies outside the idle, delimiter, halt and data sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEn | input | 1 | Transmit enable, high for the whole frame including preamble |
| txErr | input | 1 | Transmit error, replaces data with the halt group |
| txNibble | input | 4 | Transmit data nibble |
| codeOut | output | 5 | Registered 5-bit code group |

## Verification
A corrupted state register shows at the port within one clock, as a wrong delimiter, a missing start or end group, or a data group where idle should be. This holds because the output register loads straight from the next-state decode. A wrong table entry or error mux shows on the very group that uses it. For that reason the scoreboard compares every group of every cycle, not only the frame payload. Frames of minimal length, back-to-back frames with a one-cycle gap, and error pulses placed in each phase drive the state machine through every transition.

// File: rtl/nge_pkg.sv
package nge_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] GRP_IDLE  = 5'b11111;
  localparam logic [CODE_W-1:0] GRP_LEAD1 = 5'b11000;
  localparam logic [CODE_W-1:0] GRP_LEAD2 = 5'b10001;
  localparam logic [CODE_W-1:0] GRP_TAIL1 = 5'b01101;
  localparam logic [CODE_W-1:0] GRP_TAIL2 = 5'b00111;
  localparam logic [CODE_W-1:0] GRP_HALT  = 5'b00100;

  typedef enum logic [2:0] {
    ST_REST,
    ST_LEAD1,
    ST_LEAD2,
    ST_BODY,
    ST_TAIL1,
    ST_TAIL2
  } encState_t;

  // One-hot selection of the next output group; all low means idle.
  typedef struct packed {
    logic selLead1;
    logic selLead2;
    logic selBody;
    logic selTail1;
    logic selTail2;
  } encStrobe_t;

  function automatic logic [CODE_W-1:0] mapNibble(input logic [NIB_W-1:0] nib);
    logic [CODE_W-1:0] grp;
    case (nib)
      4'h0: grp = 5'b11110;
      4'h1: grp = 5'b01001;
      4'h2: grp = 5'b10100;
      4'h3: grp = 5'b10101;
      4'h4: grp = 5'b01010;
      4'h5: grp = 5'b01011;
      4'h6: grp = 5'b01110;
      4'h7: grp = 5'b01111;
      4'h8: grp = 5'b10010;
      4'h9: grp = 5'b10011;
      4'hA: grp = 5'b10110;
      4'hB: grp = 5'b10111;
      4'hC: grp = 5'b11010;
      4'hD: grp = 5'b11011;
      4'hE: grp = 5'b11100;
      default: grp = 5'b11101;
    endcase
    return grp;
  endfunction

  function automatic logic isDataGroup(input logic [CODE_W-1:0] grp);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < (1 << NIB_W); i++) begin
      if (mapNibble(NIB_W'(i)) == grp) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/nge_ctrl.sv
module nge_ctrl
  import nge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  output encStrobe_t strobe
);
  encState_t curState;
  encState_t nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_REST, ST_TAIL2: nextState = txEn ? ST_LEAD1 : ST_REST;
      ST_LEAD1:          nextState = ST_LEAD2;
      ST_LEAD2, ST_BODY: nextState = txEn ? ST_BODY : ST_TAIL1;
      ST_TAIL1:          nextState = ST_TAIL2;
      default:           nextState = ST_REST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_REST;
    else       curState <= nextState;
  end

  always_comb begin
    strobe          = '0;
    strobe.selLead1 = (nextState == ST_LEAD1);
    strobe.selLead2 = (nextState == ST_LEAD2);
    strobe.selBody  = (nextState == ST_BODY);
    strobe.selTail1 = (nextState == ST_TAIL1);
    strobe.selTail2 = (nextState == ST_TAIL2);
  end
endmodule

// File: rtl/nge_datapath.sv
module nge_datapath
  import nge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  encStrobe_t        strobe,
  input  logic              txErr,
  input  logic [NIB_W-1:0]  txNibble,
  output logic [CODE_W-1:0] codeOut
);
  logic [CODE_W-1:0] bodyGroup;
  logic [CODE_W-1:0] nextGroup;

  always_comb begin
    bodyGroup = txErr ? GRP_HALT : mapNibble(txNibble);
  end

  always_comb begin
    nextGroup = GRP_IDLE;
    if (strobe.selLead1)      nextGroup = GRP_LEAD1;
    else if (strobe.selLead2) nextGroup = GRP_LEAD2;
    else if (strobe.selBody)  nextGroup = bodyGroup;
    else if (strobe.selTail1) nextGroup = GRP_TAIL1;
    else if (strobe.selTail2) nextGroup = GRP_TAIL2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeOut <= GRP_IDLE;
    else       codeOut <= nextGroup;
  end
endmodule

// File: rtl/nibble_group_encoder.sv
module nibble_group_encoder
  import nge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEn,
  input  logic              txErr,
  input  logic [NIB_W-1:0]  txNibble,
  output logic [CODE_W-1:0] codeOut
);
  encStrobe_t strobe;

  nge_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .txEn   (txEn),
    .strobe (strobe)
  );

  nge_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .txErr    (txErr),
    .txNibble (txNibble),
    .codeOut  (codeOut)
  );
endmodule

// File: rtl/nge_checker.sv
module nge_checker
  import nge_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              txEn,
  input logic              txErr,
  input logic [CODE_W-1:0] codeOut
);
  logic inBody;
  assign inBody = (codeOut == GRP_LEAD2) || (codeOut == GRP_HALT) || isDataGroup(codeOut);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == GRP_IDLE && !txEn) |=> codeOut == GRP_IDLE);

  assert_start_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((codeOut == GRP_IDLE || codeOut == GRP_TAIL2) && txEn) |=> codeOut == GRP_LEAD1);

  assert_start_second_R3: assert property (@(posedge clk) disable iff (!rstN)
    codeOut == GRP_LEAD1 |=> codeOut == GRP_LEAD2);

  assert_body_halt_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inBody && txEn && txErr) |=> codeOut == GRP_HALT);

  assert_body_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inBody && txEn && !txErr) |=> isDataGroup(codeOut));

  assert_end_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inBody && !txEn) |=> codeOut == GRP_TAIL1);

  assert_end_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    codeOut == GRP_TAIL1 |=> codeOut == GRP_TAIL2);

  assert_return_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == GRP_TAIL2 && !txEn) |=> codeOut == GRP_IDLE);

  assert_legal_group_R9: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == GRP_IDLE || codeOut == GRP_LEAD1 || codeOut == GRP_LEAD2 ||
     codeOut == GRP_TAIL1 || codeOut == GRP_TAIL2 || codeOut == GRP_HALT ||
     isDataGroup(codeOut)));
endmodule

bind nibble_group_encoder nge_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .txEn    (txEn),
  .txErr   (txErr),
  .codeOut (codeOut)
);

// File: tb/sim_nibble_group_encoder.sv
module sim_nibble_group_encoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b0;
  logic       txErr = 1'b0;
  logic [3:0] txNibble = 4'h0;
  logic [4:0] codeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] code;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  // Reference model state: 0 rest, 1 lead1, 2 lead2, 3 body, 4 tail1, 5 tail2
  int mState = 0;
  logic [4:0] refTable [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                5'b11010, 5'b11011, 5'b11100, 5'b11101};

  always #4 clk = ~clk;

  nibble_group_encoder u0 (
    .clk      (clk),
    .rstN     (rstN),
    .txEn     (txEn),
    .txErr    (txErr),
    .txNibble (txNibble),
    .codeOut  (codeOut)
  );

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one symbol and pushes the expected output group.
  task automatic step(input logic en, input logic err, input logic [3:0] nib, input string tag);
    expItem_t it;
    @(negedge clk);
    txEn = en; txErr = err; txNibble = nib;
    case (mState)
      0, 5: mState = en ? 1 : 0;
      1:    mState = 2;
      2, 3: mState = en ? 3 : 4;
      4:    mState = 5;
      default: mState = 0;
    endcase
    case (mState)
      0: it.code = 5'b11111;
      1: it.code = 5'b11000;
      2: it.code = 5'b10001;
      3: it.code = err ? 5'b00100 : refTable[nib];
      4: it.code = 5'b01101;
      default: it.code = 5'b00111;
    endcase
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares each produced group with the scoreboard head.
  always @(posedge clk) begin
    #2;
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(codeOut, it.code, it.tag);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    txErr = 1'b1; txEn = 1'b1;
    repeat (3) @(negedge clk);
    check(codeOut, 5'b11111, "R1 reset");
    txErr = 1'b0; txEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R1: idle after reset
    repeat (3) step(1'b0, 1'b0, 4'h5, "R1 idle");
    // R8: error in idle ignored
    step(1'b0, 1'b1, 4'h3, "R8 err in idle");

    // Full frame with every nibble value
    step(1'b1, 1'b1, 4'h5, "R2 lead1 err ignored R8");
    step(1'b0, 1'b1, 4'h5, "R3 lead2 inputs ignored R8");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 4'(i), "R4 data");
    step(1'b1, 1'b1, 4'h7, "R5 halt");
    step(1'b1, 1'b0, 4'hA, "R4 data after halt");
    step(1'b0, 1'b1, 4'h0, "R6 tail1 R8");
    step(1'b0, 1'b1, 4'h0, "R6 tail2 R8");
    step(1'b0, 1'b0, 4'h0, "R7 back to idle");

    // Minimal frame: one enable cycle
    step(1'b1, 1'b0, 4'h5, "R2 lead1 short");
    step(1'b0, 1'b0, 4'h5, "R3 lead2 short");
    step(1'b0, 1'b0, 4'h0, "R6 tail1 short");
    step(1'b1, 1'b0, 4'h0, "R6 tail2 en ignored");
    // R7: back-to-back frame straight after tail2
    step(1'b1, 1'b0, 4'h5, "R7 lead1 back to back");
    step(1'b1, 1'b0, 4'hD, "R3 lead2");
    step(1'b1, 1'b1, 4'hE, "R5 halt");
    step(1'b1, 1'b0, 4'hE, "R4 data E");
    step(1'b1, 1'b0, 4'hF, "R4 data F");
    step(1'b0, 1'b0, 4'h0, "R6 tail1");
    step(1'b0, 1'b0, 4'h0, "R6 tail2");
    step(1'b0, 1'b1, 4'h0, "R1 idle R8");
    step(1'b0, 1'b0, 4'h0, "R1 idle");

    // Long random-ish frame
    step(1'b1, 1'b0, 4'h5, "R2 lead1");
    step(1'b1, 1'b0, 4'h5, "R3 lead2");
    for (int i = 0; i < 40; i++)
      step(1'b1, (i % 7) == 3, 4'((i * 5 + 3) % 16), "R4 R5 data run");
    step(1'b0, 1'b0, 4'h0, "R6 tail1");
    step(1'b0, 1'b0, 4'h0, "R6 tail2");
    step(1'b0, 1'b0, 4'h0, "R7 idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule